// File: doc/BRIEF.md
# Glitchless Redundant Clock Switchover

This block selects one of two free-running input clocks, a primary and a secondary source, and passes it to a single clock output. Changing the source never produces a shortened high or low phase. When the select input changes, the gating of the old source is withdrawn on that source's own falling edges. The output then holds low. The new source is gated in only after its own synchronizer chain has filled. Each source has a three-stage chain clocked on the falling edge of that source. A chain may start filling only when every stage of the other chain is empty. This keeps the two gates mutually exclusive even when the select input toggles rapidly.

A stopped old clock would never drain its chain. For that case a force input clears the old source's gating asynchronously, and the new source takes over using its own edges alone. An asynchronous output enable parks the output at a chosen static level. A power-down input holds the output low. A status output shows which source currently owns the output. It changes only at the moment the new source's gate opens, and it keeps the old value through the low gap.

Top module: `clk_switchover`

## Requirements
- R1: After `sel_sec` changes, the old source's gate closes by the third falling edge of the old clock. From then on `clk_out` stays low.
- R2: After the old gate has closed, `clk_out` stays low until the new source's chain has seen three of its own falling edges. It then opens on a falling edge, so the first output pulse is a full high phase of the new clock.
- R3: `sel_sec` = 0 selects the primary clock and `sel_sec` = 1 selects the secondary clock. Once the switch has settled, `clk_out` equals the selected clock.
- R4: While `force_sw` = 1, the gate of the unselected source is cleared at once, so `clk_out` drops low without any old-clock edge. The switch then completes on edges of the new clock alone.
- R5: With `force_sw` = 0, a switch away from a stopped clock stays pending. `clk_out` keeps its level and `active_sec` keeps its old value.
- R6: With `out_en` = 0 and `pwr_dn` = 0, `clk_out` equals `park_lvl` without waiting for any clock edge.
- R7: With `pwr_dn` = 1, `clk_out` is 0 whatever the values of `out_en` and `park_lvl`.
- R8: `active_sec` is 0 for the primary source and 1 for the secondary source. It changes only when the new source's gate opens and holds its old value during the low gap.
- R9: While `rst_n` = 0, both gates are closed, `clk_out` is 0 (with `out_en` = 1 and `pwr_dn` = 0) and `active_sec` is 0.
- R10: The two sources are never gated through at the same time. No `clk_out` phase is shorter than half the period of the faster input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pri_clk | input | 1 | Primary source clock |
| sec_clk | input | 1 | Secondary source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_sec | input | 1 | Source select: 0 primary, 1 secondary |
| force_sw | input | 1 | Clear the unselected source's gate without waiting for its edges |
| out_en | input | 1 | Asynchronous output enable |
| park_lvl | input | 1 | Static level of `clk_out` while disabled |
| pwr_dn | input | 1 | Power-down; holds `clk_out` low |
| clk_out | output | 1 | Switched clock output |
| active_sec | output | 1 | Source that owns the output: 0 primary, 1 secondary |

## Verification
The bench changes the select signal one nanosecond after a rising edge of the old clock. It then looks for the output low in the high phase of each following old-clock cycle, and it must find it within four cycles, since the gate closes on the third falling edge. From that point it samples the output every nanosecond for 12 ns. This window ends before the earliest rise the new source can produce, which needs three of its falling edges and one rising edge. The following of the new clock and the status are checked six new-clock cycles later. All clock checks sample 2 ns after an edge, in mid-phase. The park and power-down results are asynchronous and are sampled 1 to 2 ns after the input changes. A monitor measures every output phase against the 5 ns half-period limit.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  // index of each source in the per-source vectors
  localparam int unsigned SRC_PRI = 0;
  localparam int unsigned SRC_SEC = 1;
  localparam int unsigned NUM_SRC = 2;

  // output level after enable and power-down are applied
  function automatic logic drive_level(input logic gated, input logic oe,
                                       input logic park, input logic pd);
    if (pd)      return 1'b0;
    else if (oe) return gated;
    else         return park;
  endfunction

  // a source may start filling its chain only when it is wanted
  // and the opposite chain holds no stage at all
  function automatic logic may_fill(input logic want, input logic other_busy);
    return want & ~other_busy;
  endfunction
endpackage

// File: rtl/clksw_gate_chain.sv
`timescale 1ns/1ps
module clksw_gate_chain
  import clksw_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic want,
  input  logic force_clr,
  input  logic other_busy,
  input  logic other_en,
  output logic gate_en,
  output logic busy,
  output logic pre_en
);
  localparam int unsigned CW = $clog2(STAGES + 2);

  logic [STAGES-1:0] stg;
  logic              clr_n;

  assign clr_n = rst_n & ~force_clr;

  always_ff @(negedge clk_in or negedge clr_n) begin
    if (!clr_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], may_fill(want, other_busy)};
  end

  assign gate_en = stg[STAGES-1];
  assign pre_en  = stg[STAGES-2];
  assign busy    = |stg;

  // falling edges seen while this gate stays open after being released
  logic [CW-1:0] drop_cnt;
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n)                drop_cnt <= '0;
    else if (gate_en && !want) drop_cnt <= drop_cnt + 1'b1;
    else                       drop_cnt <= '0;
  end

  // R1
  drop_window_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    drop_cnt <= CW'(STAGES));

  // R10
  open_exclusive_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
    $rose(gate_en) |-> !other_en);
endmodule

// File: rtl/clksw_status.sv
`timescale 1ns/1ps
module clksw_status (
  input  logic sec_clk,
  input  logic pri_clk,
  input  logic rst_n,
  input  logic sel_sec,
  input  logic pre_en_sec,
  input  logic en_sec,
  input  logic en_pri,
  output logic owner_sec
);
  logic clr_n;
  assign clr_n = rst_n & ~en_pri;

  // set on the same falling edge that opens the secondary gate,
  // cleared the moment the primary gate opens
  always_ff @(negedge sec_clk or negedge clr_n) begin
    if (!clr_n)          owner_sec <= 1'b0;
    else if (pre_en_sec) owner_sec <= 1'b1;
  end

  // R8
  status_rise_chk: assert property (@(negedge sec_clk) disable iff (!rst_n)
    $rose(owner_sec) |-> (en_sec || !sel_sec));

  // R8
  status_fall_chk: assert property (@(negedge pri_clk) disable iff (!rst_n)
    $fell(owner_sec) |-> (en_pri || sel_sec));
endmodule

// File: rtl/clksw_out_stage.sv
`timescale 1ns/1ps
module clksw_out_stage
  import clksw_pkg::*;
(
  input  logic pri_clk,
  input  logic sec_clk,
  input  logic en_pri,
  input  logic en_sec,
  input  logic out_en,
  input  logic park_lvl,
  input  logic pwr_dn,
  output logic clk_out
);
  logic gated;
  assign gated   = (pri_clk & en_pri) | (sec_clk & en_sec);
  assign clk_out = drive_level(gated, out_en, park_lvl, pwr_dn);
endmodule

// File: rtl/clk_switchover.sv
`timescale 1ns/1ps
module clk_switchover
  import clksw_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic pri_clk,
  input  logic sec_clk,
  input  logic rst_n,
  input  logic sel_sec,
  input  logic force_sw,
  input  logic out_en,
  input  logic park_lvl,
  input  logic pwr_dn,
  output logic clk_out,
  output logic active_sec
);
  logic [NUM_SRC-1:0] src_clk, want, gate_en, busy, pre_en, force_clr;

  assign src_clk[SRC_PRI] = pri_clk;
  assign src_clk[SRC_SEC] = sec_clk;
  assign want[SRC_PRI]    = ~sel_sec;
  assign want[SRC_SEC]    = sel_sec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign force_clr[i] = force_sw & ~want[i];
    clksw_gate_chain #(.STAGES(STAGES)) u_chain (
      .clk_in    (src_clk[i]),
      .rst_n     (rst_n),
      .want      (want[i]),
      .force_clr (force_clr[i]),
      .other_busy(busy[NUM_SRC-1-i]),
      .other_en  (gate_en[NUM_SRC-1-i]),
      .gate_en   (gate_en[i]),
      .busy      (busy[i]),
      .pre_en    (pre_en[i])
    );
  end

  clksw_status u_status (
    .sec_clk   (sec_clk),
    .pri_clk   (pri_clk),
    .rst_n     (rst_n),
    .sel_sec   (sel_sec),
    .pre_en_sec(pre_en[SRC_SEC]),
    .en_sec    (gate_en[SRC_SEC]),
    .en_pri    (gate_en[SRC_PRI]),
    .owner_sec (active_sec)
  );

  clksw_out_stage u_out (
    .pri_clk (pri_clk),
    .sec_clk (sec_clk),
    .en_pri  (gate_en[SRC_PRI]),
    .en_sec  (gate_en[SRC_SEC]),
    .out_en  (out_en),
    .park_lvl(park_lvl),
    .pwr_dn  (pwr_dn),
    .clk_out (clk_out)
  );

  // R10
  mutex_pri_chk: assert property (@(negedge pri_clk) disable iff (!rst_n)
    !(gate_en[SRC_PRI] && gate_en[SRC_SEC]));

  // R10
  mutex_sec_chk: assert property (@(negedge sec_clk) disable iff (!rst_n)
    !(gate_en[SRC_PRI] && gate_en[SRC_SEC]));

  // R2
  pri_open_chk: assert property (@(negedge pri_clk) disable iff (!rst_n)
    pre_en[SRC_PRI] |=> (gate_en[SRC_PRI] || sel_sec));
endmodule

// File: tb/tb_clk_switchover.sv
`timescale 1ns/1ps
module tb_clk_switchover;
  logic pri_clk = 1'b0, sec_clk = 1'b0;
  logic rst_n = 1'b0, sel_sec = 1'b0, force_sw = 1'b0;
  logic out_en = 1'b1, park_lvl = 1'b0, pwr_dn = 1'b0;
  logic clk_out, active_sec;
  logic sec_freeze = 1'b0;

  int checks = 0, errors = 0, runts = 0;
  bit mon_en = 1'b0, armed = 1'b0;
  realtime last_edge = 0.0;
  localparam realtime HALF_FAST = 5.0;

  clk_switchover dut (
    .pri_clk(pri_clk), .sec_clk(sec_clk), .rst_n(rst_n), .sel_sec(sel_sec),
    .force_sw(force_sw), .out_en(out_en), .park_lvl(park_lvl),
    .pwr_dn(pwr_dn), .clk_out(clk_out), .active_sec(active_sec)
  );

  always #5 pri_clk = ~pri_clk;
  always begin
    #7;
    if (!sec_freeze) sec_clk = ~sec_clk;
  end

  // phase-width monitor (R10)
  always @(clk_out) begin
    if (mon_en) begin
      if (armed && ($realtime - last_edge) < HALF_FAST) begin
        runts++;
        $display("FAIL R10 runt phase %0t ns at %0t", $realtime - last_edge, $realtime);
      end
      last_edge = $realtime;
      armed = 1'b1;
    end else armed = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic wait_pos(input bit sec);
    if (sec) @(posedge sec_clk); else @(posedge pri_clk);
  endtask
  task automatic wait_neg(input bit sec);
    if (sec) @(negedge sec_clk); else @(negedge pri_clk);
  endtask

  // R3: output follows the selected clock in mid-phase
  task automatic t_follow(input bit sec, input string tag);
    for (int k = 0; k < 3; k++) begin
      wait_pos(sec); #2;
      chk(clk_out == 1'b1, tag, "high phase follows source", clk_out, 1'b1);
      wait_neg(sec); #2;
      chk(clk_out == 1'b0, tag, "low phase follows source", clk_out, 1'b0);
    end
  endtask

  task automatic t_reset();
    #23;
    chk(clk_out == 1'b0, "R9", "clk_out in reset", clk_out, 1'b0);
    chk(active_sec == 1'b0, "R9", "active_sec in reset", active_sec, 1'b0);
    @(posedge pri_clk); #1 rst_n = 1'b1;
    repeat (6) @(posedge pri_clk);
    chk(active_sec == 1'b0, "R8", "primary owns after reset", active_sec, 1'b0);
    t_follow(1'b0, "R3");
  endtask

  // R1, R2, R8, R3: a normal switch toward 'to_sec'
  task automatic t_switch(input bit to_sec);
    bit old_sec = !to_sec;
    int found = -1;
    bit gap_ok = 1'b1;
    wait_pos(old_sec); #1 sel_sec = to_sec;
    for (int k = 0; k < 6; k++) begin
      wait_pos(old_sec); #2;
      if (clk_out == 1'b0) begin found = k; break; end
    end
    chk(found >= 0 && found <= 3, "R1", "old gate closed within 3 old falling edges",
        found >= 0, 1'b1);
    chk(active_sec == old_sec, "R8", "status holds old source in gap", active_sec, old_sec);
    for (int t = 0; t < 12; t++) begin
      if (clk_out != 1'b0) gap_ok = 1'b0;
      #1;
    end
    chk(gap_ok, "R2", "output low through gap", !gap_ok, 1'b0);
    repeat (6) wait_pos(to_sec);
    chk(active_sec == to_sec, "R8", "status names new source", active_sec, to_sec);
    t_follow(to_sec, "R3");
  endtask

  // R5 then R4: old (secondary) clock stopped high
  task automatic t_forced();
    @(posedge sec_clk); sec_freeze = 1'b1;
    #2;
    chk(clk_out == 1'b1, "R5", "frozen source held high at output", clk_out, 1'b1);
    sel_sec = 1'b0;
    repeat (8) @(posedge pri_clk);
    #2;
    chk(clk_out == 1'b1, "R5", "switch pending without force", clk_out, 1'b1);
    chk(active_sec == 1'b1, "R5", "status unchanged without force", active_sec, 1'b1);
    force_sw = 1'b1;
    #1;
    chk(clk_out == 1'b0, "R4", "forced clear drops output", clk_out, 1'b0);
    chk(active_sec == 1'b1, "R8", "status holds during forced gap", active_sec, 1'b1);
    repeat (6) @(posedge pri_clk);
    chk(active_sec == 1'b0, "R4", "forced switch completes", active_sec, 1'b0);
    t_follow(1'b0, "R4");
    sec_freeze = 1'b0;
    force_sw = 1'b0;
    repeat (4) @(posedge pri_clk);
    t_follow(1'b0, "R3");
  endtask

  // R6, R7: asynchronous park and power-down
  task automatic t_park_pd();
    mon_en = 1'b0;
    @(negedge pri_clk); #2;
    out_en = 1'b0; park_lvl = 1'b1; #1;
    chk(clk_out == 1'b1, "R6", "park high in low phase", clk_out, 1'b1);
    @(posedge pri_clk); #2;
    chk(clk_out == 1'b1, "R6", "park high in high phase", clk_out, 1'b1);
    park_lvl = 1'b0; #1;
    chk(clk_out == 1'b0, "R6", "park low in high phase", clk_out, 1'b0);
    park_lvl = 1'b1; pwr_dn = 1'b1; #1;
    chk(clk_out == 1'b0, "R7", "power-down beats park high", clk_out, 1'b0);
    out_en = 1'b1;
    @(posedge pri_clk); #2;
    chk(clk_out == 1'b0, "R7", "power-down beats enabled clock", clk_out, 1'b0);
    pwr_dn = 1'b0; park_lvl = 1'b0;
    t_follow(1'b0, "R3");
  endtask

  initial begin
    t_reset();
    mon_en = 1'b1;
    t_switch(1'b1);
    t_switch(1'b0);
    t_switch(1'b1);
    t_forced();
    t_switch(1'b1);
    t_switch(1'b0);
    t_park_pd();
    chk(runts == 0, "R10", "no short output phase", runts != 0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule